// File: doc/BRIEF.md
# Status LED Driver with Strap-Selected Polarity

This block turns the line status of a 10/100 Ethernet transceiver into four LED pin levels: activity, link, 100 Mbit/s speed and full duplex. Each pin's electrical polarity comes from a strap bit. During hardware reset the block follows the strap inputs. When reset is released it keeps the value from the last clock edge of reset. A strap bit at 1 gives an active-low pin, so the LED is wired to the supply. A strap bit at 0 gives an active-high pin.

The activity pin lights while carrier sense is present. After carrier sense drops, it stays lit for a hold period set by parameters: `HOLD_MS` milliseconds of a `CLK_FREQ_HZ` clock, which is 128 ms at 25 MHz by default. The link pin follows the link-valid flag of whichever speed is currently selected. The speed pin lights at 100 Mbit/s or during auto-negotiation, and an isolate control forces it off. The duplex pin lights for a full-duplex link. Every pin is registered, so a pin shows the inputs sampled at the previous rising clock edge.

Vector bit order is the same for `strap_i` and `led_o`: bit 0 is activity, bit 1 is link, bit 2 is speed, bit 3 is duplex.

Top module: `stat_led_drv`

## Requirements
- R1: For each bit n, the latched polarity equals `strap_i[n]` at the last rising edge where `rst` was high. A latched 1 makes `led_o[n]` drive 0 when lit and 1 when dark. A latched 0 does the reverse. Changes on `strap_i` while `rst` is low have no effect.
- R2: After a rising edge that samples `crs_i` high, `led_o[0]` is at its lit level.
- R3: After the last edge that sampled `crs_i` high, `led_o[0]` stays lit for exactly HOLD = (`CLK_FREQ_HZ`/1000)·`HOLD_MS` further edges and is dark after the next one.
- R4: If carrier sense rises again during the hold period, the hold period restarts from its full length.
- R5: `led_o[1]` is lit when the selected link flag is 1: `link100_i` if `sel100_i` is 1, otherwise `link10_i`.
- R6: `led_o[2]` is dark whenever `isolate_i` is 1. Otherwise it is lit exactly when `sel100_i` or `aneg_busy_i` is 1, so it is dark at 10 Mbit/s with no negotiation in progress.
- R7: `led_o[3]` is lit when `full_dup_i` is 1 and the R5 link condition holds, and is dark otherwise.
- R8: At each edge with `rst` high, every pin takes its dark level, which equals `strap_i` at that edge. The activity hold timer is cleared, so carrier sense seen during reset leaves no trace afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| crs_i | input | 1 | Carrier sense |
| link10_i | input | 1 | 10 Mbit/s link valid |
| link100_i | input | 1 | 100 Mbit/s link valid |
| sel100_i | input | 1 | Selected speed is 100 Mbit/s |
| aneg_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | Line isolate control |
| full_dup_i | input | 1 | Link runs full duplex |
| strap_i | input | 4 | Polarity straps, sampled during reset |
| led_o | output | 4 | LED pin levels |

## Verification
The assertions assume that every status input is synchronous to `clk` and is meaningful at every edge once reset is released. They also assume that each reset pulse spans at least one rising edge, which is what lets the checker's own polarity copy and idle counter start from a known value. The stimulus changes inputs only on falling edges. It holds `rst` high for two edges in every reset. After release it drives `strap_i` to the inverse of the latched value, so a pin that followed the live strap would show up immediately.

// File: rtl/stat_led_pkg.sv
package stat_led_pkg;

    localparam int unsigned LED_N    = 4;
    localparam int unsigned IDX_ACT  = 0;
    localparam int unsigned IDX_LINK = 1;
    localparam int unsigned IDX_SPD  = 2;
    localparam int unsigned IDX_FDX  = 3;

    // Line status presented to the LED condition logic.
    typedef struct packed {
        logic link10;
        logic link100;
        logic sel100;
        logic aneg_busy;
        logic isolate;
        logic fdx;
    } line_stat_t;

    // Lit/dark request per LED, activity in the least significant position.
    typedef struct packed {
        logic fdx;
        logic spd;
        logic link;
        logic act;
    } led_vec_t;

    function automatic int unsigned hold_len(int unsigned hz, int unsigned ms);
        return (hz / 1000) * ms;
    endfunction

    function automatic logic link_pick(line_stat_t s);
        return s.sel100 ? s.link100 : s.link10;
    endfunction

    function automatic logic speed_lit(line_stat_t s);
        return (s.sel100 | s.aneg_busy) & ~s.isolate;
    endfunction

    // Pin level: a lit LED drives the opposite of its dark level (the strap).
    function automatic logic pin_level(logic lit, logic dark_lvl);
        return lit ^ dark_lvl;
    endfunction

endpackage

// File: rtl/stat_led_strap.sv
module stat_led_strap #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] pol_o
);
    logic [W-1:0] pol_q;

    // Tracks the straps through reset; holds the final value once released.
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= strap_i;
        end
    end

    assign pol_o = pol_q;
endmodule

// File: rtl/stat_led_stretch.sv
module stat_led_stretch #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic crs_i,
    output logic active_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] ONE    = CW'(1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (crs_i) begin
            left_q <= RELOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - ONE;
        end
    end

    assign active_o = crs_i | (left_q != '0);
endmodule

// File: rtl/stat_led_cond.sv
module stat_led_cond
    import stat_led_pkg::*;
(
    input  line_stat_t stat_i,
    input  logic       act_i,
    output led_vec_t   lit_o
);
    logic link_ok;

    always_comb begin
        link_ok     = link_pick(stat_i);
        lit_o.act   = act_i;
        lit_o.link  = link_ok;
        lit_o.spd   = speed_lit(stat_i);
        lit_o.fdx   = stat_i.fdx & link_ok;
    end
endmodule

// File: rtl/stat_led_drv.sv
module stat_led_drv
    import stat_led_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 25_000_000,
    parameter int unsigned HOLD_MS     = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             crs_i,
    input  logic             link10_i,
    input  logic             link100_i,
    input  logic             sel100_i,
    input  logic             aneg_busy_i,
    input  logic             isolate_i,
    input  logic             full_dup_i,
    input  logic [LED_N-1:0] strap_i,
    output logic [LED_N-1:0] led_o
);
    localparam int unsigned HOLD_CYCLES = hold_len(CLK_FREQ_HZ, HOLD_MS);

    line_stat_t       stat;
    led_vec_t         lit;
    logic [LED_N-1:0] lit_bits;
    logic [LED_N-1:0] pol;
    logic             act_on;
    logic [LED_N-1:0] led_q;

    always_comb begin
        stat.link10    = link10_i;
        stat.link100   = link100_i;
        stat.sel100    = sel100_i;
        stat.aneg_busy = aneg_busy_i;
        stat.isolate   = isolate_i;
        stat.fdx       = full_dup_i;
    end

    stat_led_strap #(.W(LED_N)) strap_i0 (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .pol_o   (pol)
    );

    stat_led_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) act_i0 (
        .clk      (clk),
        .rst      (rst),
        .crs_i    (crs_i),
        .active_o (act_on)
    );

    stat_led_cond cond_i0 (
        .stat_i (stat),
        .act_i  (act_on),
        .lit_o  (lit)
    );

    assign lit_bits = lit;

    for (genvar n = 0; n < LED_N; n++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                led_q[n] <= strap_i[n];
            end else begin
                led_q[n] <= pin_level(lit_bits[n], pol[n]);
            end
        end
    end

    assign led_o = led_q;
endmodule

// File: rtl/stat_led_drv_chk.sv
module stat_led_drv_chk #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       crs_i,
    input logic       link10_i,
    input logic       link100_i,
    input logic       sel100_i,
    input logic       aneg_busy_i,
    input logic       isolate_i,
    input logic       full_dup_i,
    input logic [3:0] strap_i,
    input logic [3:0] led_o
);
    localparam int unsigned IW = $clog2(HOLD_CYCLES + 2);
    localparam logic [IW-1:0] IDLE_SAT = IW'(HOLD_CYCLES + 1);
    localparam logic [IW-1:0] HOLD_V   = IW'(HOLD_CYCLES);
    localparam logic [IW-1:0] ONE      = IW'(1);

    logic [3:0]    pol_seen;
    logic [IW-1:0] idle_q;

    // Edges since carrier sense was last sampled high, saturating.
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_seen <= strap_i;
            idle_q   <= IDLE_SAT;
        end else if (crs_i) begin
            idle_q <= '0;
        end else if (idle_q != IDLE_SAT) begin
            idle_q <= idle_q + ONE;
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (led_o == $past(strap_i))); // R8

    AST_ACT_ON: assert property (@(posedge clk) disable iff (rst)
        (idle_q == '0) |-> (led_o[0] == ~pol_seen[0])); // R2

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idle_q <= HOLD_V) |-> (led_o[0] == ~pol_seen[0])); // R4

    AST_ACT_OFF: assert property (@(posedge clk) disable iff (rst)
        (idle_q > HOLD_V) |-> (led_o[0] == pol_seen[0])); // R3

    AST_LINK_SEL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (led_o[1] ==
            (($past(sel100_i) ? $past(link100_i) : $past(link10_i)) ^ pol_seen[1]))); // R5

    AST_SPD_ISO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(isolate_i)) |-> (led_o[2] == pol_seen[2])); // R6

    AST_SPD_ON: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(isolate_i) && ($past(sel100_i) || $past(aneg_busy_i)))
        |-> (led_o[2] == ~pol_seen[2])); // R6

    AST_FDX_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(full_dup_i)) |-> (led_o[3] == pol_seen[3])); // R7

    AST_POL_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(crs_i) && (idle_q > HOLD_V)) |-> (led_o[0] == pol_seen[0])); // R1
endmodule

bind stat_led_drv stat_led_drv_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .crs_i       (crs_i),
    .link10_i    (link10_i),
    .link100_i   (link100_i),
    .sel100_i    (sel100_i),
    .aneg_busy_i (aneg_busy_i),
    .isolate_i   (isolate_i),
    .full_dup_i  (full_dup_i),
    .strap_i     (strap_i),
    .led_o       (led_o)
);

// File: tb/stat_led_drv_tb_top.sv
`timescale 1ns/1ps
module stat_led_drv_tb_top;
    localparam int unsigned TB_HZ = 8000;
    localparam int unsigned TB_MS = 1;
    localparam int unsigned HOLD  = (TB_HZ / 1000) * TB_MS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       crs = 1'b0;
    logic       l10 = 1'b0, l100 = 1'b0, s100 = 1'b0, an = 1'b0, iso = 1'b0, fdx = 1'b0;
    logic [3:0] strap = 4'h0;
    logic [3:0] led;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    stat_led_drv #(.CLK_FREQ_HZ(TB_HZ), .HOLD_MS(TB_MS)) dut_i (
        .clk(clk), .rst(rst), .crs_i(crs), .link10_i(l10), .link100_i(l100),
        .sel100_i(s100), .aneg_busy_i(an), .isolate_i(iso), .full_dup_i(fdx),
        .strap_i(strap), .led_o(led)
    );

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic set_stat(logic [5:0] st);
        l10 = st[0]; l100 = st[1]; s100 = st[2]; an = st[3]; iso = st[4]; fdx = st[5];
    endtask

    // Expected lit vector {fdx,spd,link,act} from the requirements.
    function automatic logic [3:0] lit_of(logic act, logic [5:0] st);
        logic link, spd, dup;
        link = st[2] ? st[1] : st[0];
        spd  = (st[2] | st[3]) & ~st[4];
        dup  = st[5] & link;
        return {dup, spd, link, act};
    endfunction

    task automatic do_reset(logic [3:0] s);
        @(negedge clk);
        rst = 1'b1; strap = s; crs = 1'b1; set_stat(6'h3f);
        @(negedge clk);
        chk("R8 reset level", led, s);
        @(negedge clk);
        chk("R8 reset level held", led, s);
        rst = 1'b0; crs = 1'b0; set_stat(6'h00); strap = ~s;
        @(negedge clk);
        chk("R8 timer cleared, R1 polarity", led, s);
    endtask

    task automatic act_run(logic [3:0] s, int unsigned hi_len, string tag);
        crs = 1'b1;
        for (int unsigned k = 0; k < hi_len; k++) begin
            @(negedge clk);
            chk({"R2 ", tag}, led, s ^ 4'b0001);
        end
        crs = 1'b0;
        for (int unsigned i = 1; i <= HOLD + 1; i++) begin
            @(negedge clk);
            chk({"R3 ", tag}, led, s ^ ((i <= HOLD) ? 4'b0001 : 4'b0000));
        end
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int sv = 0; sv < 16; sv++) begin
            logic [3:0] s;
            s = 4'(sv);
            do_reset(s);
            // Full sweep of the six status inputs with carrier idle.
            for (int st = 0; st < 64; st++) begin
                logic [3:0] e;
                set_stat(6'(st));
                @(negedge clk);
                e = lit_of(1'b0, 6'(st)) ^ s;
                chk("R1 activity dark, strap ignored", {3'b000, led[0]}, {3'b000, e[0]});
                chk("R5 link select", {3'b000, led[1]}, {3'b000, e[1]});
                chk("R6 speed", {3'b000, led[2]}, {3'b000, e[2]});
                chk("R7 duplex", {3'b000, led[3]}, {3'b000, e[3]});
            end
            set_stat(6'h00);
            @(negedge clk);
            act_run(s, 1, "single pulse");
            act_run(s, 5, "long carrier");
            // Retrigger inside the hold window.
            crs = 1'b1;
            @(negedge clk);
            crs = 1'b0;
            for (int unsigned i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R4 before retrigger", led, s ^ 4'b0001);
            end
            act_run(s, 1, "R4 retrigger restart");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule